// File: doc/BRIEF.md
# Full-Map Directory Home Controller

This block is the home node for a small range of memory blocks shared by a fixed number of caching nodes. For every block it holds a full presence vector, with one bit per node, and a single dirty bit. Caching nodes send it read-miss and write-miss requests tagged with their node number. The controller then does the work the directory entry calls for:

- it sends invalidations to the sharers, or a fetch or fetch-with-invalidate to a dirty owner;
- it collects the acknowledgements;
- it reads or writes back the memory block;
- it returns the line to the requester.

All message ports use a simple valid/ready or valid-only handshake. The controller handles one transaction at a time. It accepts nothing new until the requesting node reports completion, so the home node sets the order of all requests to a block. Requests waiting for other blocks queue outside the block.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, every directory entry is clean with no presence bits set, `busy_o` is low, `req_ready_o` is high, and no probe, reply or memory command is valid.
- R2: On a read miss to a clean block, the controller issues one memory read and replies with the memory data. It then adds the requester to the presence vector and leaves the block clean.
- R3: On a read miss to a dirty block, the controller sends probe kind 1 (fetch) to the owner and writes the returned line to memory. It replies with that line, clears dirty and keeps the owner as a sharer beside the requester.
- R4: On a write miss to a clean block, the controller sends probe kind 0 (invalidate) to every present node except the requester, in ascending node order. It then reads memory, replies, and leaves only the requester present with dirty set.
- R5: On a write miss to a dirty block, the controller sends probe kind 2 (fetch-invalidate) to the owner and replies with the returned line without any memory traffic. The requester becomes the sole present node and dirty stays set.
- R6: The reply is held back until the number of acknowledgements received equals the number of probes sent. That number is the population count of the nodes targeted.
- R7: From request acceptance until a completion message carrying the requester's node number, `busy_o` is high and `req_ready_o` is low. A completion from any other node is ignored.
- R8: Whenever an entry is written dirty, exactly one presence bit is set, so a later recall goes to exactly one node.
- R9: At most one of probe, reply and memory command is valid in any cycle. A reply held against a low `rep_ready_i` keeps its data stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Miss request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_write_i | input | 1 | 1 = write miss, 0 = read miss |
| req_node_i | input | NODE_W | Requesting node |
| req_blk_i | input | BLK_W | Block index |
| prb_valid_o | output | 1 | Probe message valid |
| prb_ready_i | input | 1 | Probe accepted |
| prb_kind_o | output | 2 | 0 invalidate, 1 fetch, 2 fetch-invalidate |
| prb_node_o | output | NODE_W | Probe destination |
| prb_blk_o | output | BLK_W | Probed block |
| ack_valid_i | input | 1 | Probe acknowledgement |
| ack_data_i | input | DATA_W | Line data carried by a fetch acknowledgement |
| mem_valid_o | output | 1 | Memory command valid |
| mem_write_o | output | 1 | 1 = writeback, 0 = read |
| mem_blk_o | output | BLK_W | Memory block |
| mem_wdata_o | output | DATA_W | Writeback data |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | DATA_W | Memory read data |
| rep_valid_o | output | 1 | Data reply valid |
| rep_ready_i | input | 1 | Reply accepted |
| rep_node_o | output | NODE_W | Reply destination |
| rep_blk_o | output | BLK_W | Reply block |
| rep_data_o | output | DATA_W | Reply line data |
| done_valid_i | input | 1 | Completion message |
| done_node_i | input | NODE_W | Node sending completion |
| busy_o | output | 1 | Transaction in flight |

## Verification
The assertions take the following for granted:

- each probe gets exactly one acknowledgement, and only after the probe is accepted;
- memory accepts a command in the cycle it is offered and answers a read with a single data pulse;
- a dirty owner never misses on its own block.

The stimulus keeps to these rules. A reactive responder acknowledges each observed probe on the next half-cycle and answers memory reads one cycle late. The request sequence never makes the current owner the requester of a recall.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    PRB_INV       = 2'd0,
    PRB_FETCH     = 2'd1,
    PRB_FETCH_INV = 2'd2
  } prb_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PROBE, ST_ACKS, ST_MEM_RD, ST_MEM_WR, ST_REPLY, ST_DONE
  } home_st_e;
endpackage

// File: rtl/dir_entry_store.sv
module dir_entry_store #(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  localparam int BLK_W = $clog2(BLOCKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BLK_W-1:0] rd_blk_i,
  output logic [NODES-1:0] rd_pres_o,
  output logic             rd_dirty_o,
  input  logic             wr_en_i,
  input  logic [BLK_W-1:0] wr_blk_i,
  input  logic [NODES-1:0] wr_pres_i,
  input  logic             wr_dirty_i
);
  logic [NODES-1:0] pres_q  [BLOCKS];
  logic             dirty_q [BLOCKS];

  for (genvar g = 0; g < BLOCKS; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pres_q[g]  <= '0;
        dirty_q[g] <= 1'b0;
      end else if (wr_en_i && wr_blk_i == BLK_W'(g)) begin
        pres_q[g]  <= wr_pres_i;
        dirty_q[g] <= wr_dirty_i;
      end
    end
  end

  assign rd_pres_o  = pres_q[rd_blk_i];
  assign rd_dirty_o = dirty_q[rd_blk_i];
endmodule

// File: rtl/dir_sharer_pick.sv
module dir_sharer_pick #(
  parameter int NODES = 4,
  localparam int NODE_W = $clog2(NODES)
) (
  input  logic [NODES-1:0]  vec_i,
  output logic              any_o,
  output logic [NODE_W-1:0] idx_o
);
  assign any_o = |vec_i;

  // lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int k = NODES - 1; k >= 0; k--) begin
      if (vec_i[k]) idx_o = NODE_W'(k);
    end
  end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl #(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  parameter int DATA_W = 32,
  localparam int NODE_W = $clog2(NODES),
  localparam int BLK_W  = $clog2(BLOCKS),
  localparam int CNT_W  = $clog2(NODES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [NODE_W-1:0] req_node_i,
  input  logic [BLK_W-1:0]  req_blk_i,
  output logic              prb_valid_o,
  input  logic              prb_ready_i,
  output logic [1:0]        prb_kind_o,
  output logic [NODE_W-1:0] prb_node_o,
  output logic [BLK_W-1:0]  prb_blk_o,
  input  logic              ack_valid_i,
  input  logic [DATA_W-1:0] ack_data_i,
  output logic              mem_valid_o,
  output logic              mem_write_o,
  output logic [BLK_W-1:0]  mem_blk_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              rep_valid_o,
  input  logic              rep_ready_i,
  output logic [NODE_W-1:0] rep_node_o,
  output logic [BLK_W-1:0]  rep_blk_o,
  output logic [DATA_W-1:0] rep_data_o,
  input  logic              done_valid_i,
  input  logic [NODE_W-1:0] done_node_i,
  output logic              busy_o
);
  import dir_pkg::*;

  home_st_e          state_q;
  logic              cur_write_q, cur_dirty_q, mem_sent_q;
  logic [NODE_W-1:0] cur_node_q;
  logic [BLK_W-1:0]  cur_blk_q;
  logic [NODES-1:0]  cur_pres_q, pend_q;
  logic [CNT_W-1:0]  ack_cnt;
  logic [DATA_W-1:0] data_q;

  logic [NODES-1:0]  rd_pres, req_bit, sharers, cur_bit;
  logic              rd_dirty, pend_any, accept;
  logic [NODE_W-1:0] pend_idx;
  logic [CNT_W-1:0]  sharer_cnt;
  logic              dir_wr_en, dir_wr_dirty;
  logic [NODES-1:0]  dir_wr_pres;

  dir_entry_store #(.NODES(NODES), .BLOCKS(BLOCKS)) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_blk_i   (req_blk_i),
    .rd_pres_o  (rd_pres),
    .rd_dirty_o (rd_dirty),
    .wr_en_i    (dir_wr_en),
    .wr_blk_i   (cur_blk_q),
    .wr_pres_i  (dir_wr_pres),
    .wr_dirty_i (dir_wr_dirty)
  );

  dir_sharer_pick #(.NODES(NODES)) i_pick (
    .vec_i (pend_q),
    .any_o (pend_any),
    .idx_o (pend_idx)
  );

  assign accept  = (state_q == ST_IDLE) && req_valid_i;
  assign req_bit = NODES'(1) << req_node_i;
  assign cur_bit = NODES'(1) << cur_node_q;
  // requester's own copy is never invalidated
  assign sharers = rd_pres & ~req_bit;

  always_comb begin
    sharer_cnt = '0;
    for (int k = 0; k < NODES; k++) sharer_cnt = sharer_cnt + CNT_W'(sharers[k]);
  end

  assign dir_wr_en    = (state_q == ST_REPLY) && rep_ready_i;
  assign dir_wr_dirty = cur_write_q;
  assign dir_wr_pres  = cur_write_q ? cur_bit : (cur_pres_q | cur_bit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cur_write_q <= 1'b0;
      cur_dirty_q <= 1'b0;
      cur_node_q  <= '0;
      cur_blk_q   <= '0;
      cur_pres_q  <= '0;
      pend_q      <= '0;
      ack_cnt     <= '0;
      data_q      <= '0;
      mem_sent_q  <= 1'b0;
    end else begin
      if (ack_valid_i && ack_cnt != '0) begin
        ack_cnt <= ack_cnt - CNT_W'(1);
        data_q  <= ack_data_i;
      end
      unique case (state_q)
        ST_IDLE: if (accept) begin
          cur_write_q <= req_write_i;
          cur_dirty_q <= rd_dirty;
          cur_node_q  <= req_node_i;
          cur_blk_q   <= req_blk_i;
          cur_pres_q  <= rd_pres;
          if (rd_dirty) begin
            pend_q  <= rd_pres;
            ack_cnt <= CNT_W'(1);
            state_q <= ST_PROBE;
          end else if (req_write_i && sharers != '0) begin
            pend_q  <= sharers;
            ack_cnt <= sharer_cnt;
            state_q <= ST_PROBE;
          end else begin
            pend_q  <= '0;
            ack_cnt <= '0;
            state_q <= ST_MEM_RD;
          end
        end
        ST_PROBE: begin
          if (!pend_any) state_q <= ST_ACKS;
          else if (prb_ready_i) pend_q[pend_idx] <= 1'b0;
        end
        ST_ACKS: if (ack_cnt == '0) begin
          if (!cur_dirty_q)     state_q <= ST_MEM_RD;
          else if (cur_write_q) state_q <= ST_REPLY;
          else                  state_q <= ST_MEM_WR;
        end
        ST_MEM_RD: begin
          if (!mem_sent_q) mem_sent_q <= 1'b1;
          else if (mem_rvalid_i) begin
            mem_sent_q <= 1'b0;
            data_q     <= mem_rdata_i;
            state_q    <= ST_REPLY;
          end
        end
        ST_MEM_WR: state_q <= ST_REPLY;
        ST_REPLY:  if (rep_ready_i) state_q <= ST_DONE;
        ST_DONE:   if (done_valid_i && done_node_i == cur_node_q) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign busy_o      = (state_q != ST_IDLE);
  assign prb_valid_o = (state_q == ST_PROBE) && pend_any;
  assign prb_kind_o  = !cur_dirty_q ? PRB_INV : (cur_write_q ? PRB_FETCH_INV : PRB_FETCH);
  assign prb_node_o  = pend_idx;
  assign prb_blk_o   = cur_blk_q;
  assign mem_valid_o = ((state_q == ST_MEM_RD) && !mem_sent_q) || (state_q == ST_MEM_WR);
  assign mem_write_o = (state_q == ST_MEM_WR);
  assign mem_blk_o   = cur_blk_q;
  assign mem_wdata_o = data_q;
  assign rep_valid_o = (state_q == ST_REPLY);
  assign rep_node_o  = cur_node_q;
  assign rep_blk_o   = cur_blk_q;
  assign rep_data_o  = data_q;
endmodule

// File: rtl/dir_home_checker.sv
module dir_home_checker #(
  parameter int NODES  = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              busy_o,
  input logic              prb_valid_o,
  input logic              rep_valid_o,
  input logic              rep_ready_i,
  input logic [DATA_W-1:0] rep_data_o,
  input logic              mem_valid_o,
  input logic [CNT_W-1:0]  ack_cnt,
  input logic              dir_wr_en,
  input logic              dir_wr_dirty,
  input logic [NODES-1:0]  dir_wr_pres
);
  assert_accept_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> busy_o && !req_ready_o);

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !prb_valid_o && !rep_valid_o && !mem_valid_o);

  assert_reply_after_acks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep_valid_o |-> ack_cnt == '0);

  assert_dirty_single_owner_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_wr_en && dir_wr_dirty |-> $countones(dir_wr_pres) == 1);

  assert_one_message_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prb_valid_o, rep_valid_o, mem_valid_o}));

  assert_reply_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep_valid_o && !rep_ready_i |=> rep_valid_o && $stable(rep_data_o));
endmodule

bind dir_home_ctrl dir_home_checker #(.NODES(NODES), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .busy_o       (busy_o),
  .prb_valid_o  (prb_valid_o),
  .rep_valid_o  (rep_valid_o),
  .rep_ready_i  (rep_ready_i),
  .rep_data_o   (rep_data_o),
  .mem_valid_o  (mem_valid_o),
  .ack_cnt      (ack_cnt),
  .dir_wr_en    (dir_wr_en),
  .dir_wr_dirty (dir_wr_dirty),
  .dir_wr_pres  (dir_wr_pres)
);

// File: tb/test_dir_home_ctrl.sv
`timescale 1ns/1ps
module test_dir_home_ctrl;
  localparam int NODES = 4, BLOCKS = 8, DATA_W = 32;
  localparam int NW = $clog2(NODES), BW = $clog2(BLOCKS);

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic              req_valid = 0, req_write = 0;
  logic [NW-1:0]     req_node = 0;
  logic [BW-1:0]     req_blk = 0;
  logic              req_ready, prb_valid, mem_valid, mem_write, rep_valid, busy;
  logic [1:0]        prb_kind;
  logic [NW-1:0]     prb_node, rep_node;
  logic [BW-1:0]     prb_blk, mem_blk, rep_blk;
  logic [DATA_W-1:0] mem_wdata, rep_data;
  logic              ack_valid = 0, mem_rvalid = 0, done_valid = 0;
  logic [DATA_W-1:0] ack_data = 0, mem_rdata = 0;
  logic [NW-1:0]     done_node = 0;

  dir_home_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) i_dir_home_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_node_i(req_node), .req_blk_i(req_blk),
    .prb_valid_o(prb_valid), .prb_ready_i(1'b1), .prb_kind_o(prb_kind),
    .prb_node_o(prb_node), .prb_blk_o(prb_blk),
    .ack_valid_i(ack_valid), .ack_data_i(ack_data),
    .mem_valid_o(mem_valid), .mem_write_o(mem_write), .mem_blk_o(mem_blk),
    .mem_wdata_o(mem_wdata), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .rep_valid_o(rep_valid), .rep_ready_i(1'b1), .rep_node_o(rep_node),
    .rep_blk_o(rep_blk), .rep_data_o(rep_data),
    .done_valid_i(done_valid), .done_node_i(done_node), .busy_o(busy)
  );

  int n_cmp = 0, n_bad = 0, rep_seen = 0, outstanding = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench models: directory, memory, node lines
  logic [NODES-1:0]  dp [BLOCKS];
  logic              dd [BLOCKS];
  logic [DATA_W-1:0] exp_mem [BLOCKS];
  logic [DATA_W-1:0] mem_m [BLOCKS];
  logic [DATA_W-1:0] line [NODES][BLOCKS];
  int seq = 0;

  // scoreboard queues
  logic [15:0]         exp_prb [$];  // {kind, node, blk}
  logic [DATA_W+15:0]  exp_rep [$];  // {node, blk, data}
  logic [DATA_W+15:0]  exp_mwr [$];  // {blk, data}
  string               exp_tag [$];
  logic [DATA_W-1:0]   ack_q [$];
  bit                  rd_pend = 0;
  logic [BW-1:0]       rd_blk = 0;

  function automatic int owner_of(input logic [NODES-1:0] v);
    for (int k = 0; k < NODES; k++) if (v[k]) return k;
    return 0;
  endfunction

  // monitor and responder
  always @(negedge clk) begin
    mem_rvalid = 0;
    ack_valid  = 0;
    if (rd_pend) begin
      mem_rvalid = 1; mem_rdata = mem_m[rd_blk]; rd_pend = 0;
    end
    if (ack_q.size() > 0) begin
      ack_valid = 1; ack_data = ack_q.pop_front(); outstanding--;
    end
    if (rst_n && mem_valid) begin
      if (!mem_write) begin
        rd_pend = 1; rd_blk = mem_blk;
      end else begin
        logic [DATA_W+15:0] e;
        e = (exp_mwr.size() > 0) ? exp_mwr.pop_front() : '1;
        chk({16'(mem_blk), mem_wdata} == e, "R3 writeback", {16'(mem_blk), mem_wdata}, e);
        mem_m[mem_blk] = mem_wdata;
      end
    end
    if (rst_n && prb_valid) begin
      logic [15:0] e;
      e = (exp_prb.size() > 0) ? exp_prb.pop_front() : '1;
      chk({4'(prb_kind), 4'(prb_node), 8'(prb_blk)} == e, exp_tag[0],
          {4'(prb_kind), 4'(prb_node), 8'(prb_blk)}, e);
      ack_q.push_back(prb_kind == 2'd0 ? '0 : line[prb_node][prb_blk]);
      outstanding++;
    end
    if (rst_n && rep_valid) begin
      logic [DATA_W+15:0] e;
      e = (exp_rep.size() > 0) ? exp_rep.pop_front() : '1;
      chk({8'(rep_node), 8'(rep_blk), rep_data} == e, exp_tag[0],
          {8'(rep_node), 8'(rep_blk), rep_data}, e);
      chk(outstanding == 0 && ack_q.size() == 0, "R6 acks before reply",
          64'(outstanding), 64'd0);
      rep_seen++;
    end
  end

  task automatic do_req(input bit w, input int n, input int b, input string tag);
    logic [NODES-1:0] pres, bit_n;
    int own, old;
    pres  = dp[b];
    bit_n = NODES'(1) << n;
    exp_tag.delete(); exp_tag.push_back(tag);
    if (!w && !dd[b]) begin                         // R2
      exp_rep.push_back({8'(n), 8'(b), exp_mem[b]});
      dp[b] = pres | bit_n;
    end else if (!w) begin                          // R3
      own = owner_of(pres);
      exp_prb.push_back({4'd1, 4'(own), 8'(b)});
      exp_mwr.push_back({16'(b), line[own][b]});
      exp_mem[b] = line[own][b];
      exp_rep.push_back({8'(n), 8'(b), line[own][b]});
      dp[b] = pres | bit_n; dd[b] = 0;
    end else if (!dd[b]) begin                      // R4: ascending, skip requester
      for (int k = 0; k < NODES; k++)
        if (pres[k] && k != n) exp_prb.push_back({4'd0, 4'(k), 8'(b)});
      exp_rep.push_back({8'(n), 8'(b), exp_mem[b]});
      dp[b] = bit_n; dd[b] = 1;
    end else begin                                  // R5, R8: single owner recalled
      own = owner_of(pres);
      exp_prb.push_back({4'd2, 4'(own), 8'(b)});
      exp_rep.push_back({8'(n), 8'(b), line[own][b]});
      dp[b] = bit_n;
    end
    if (w) begin
      seq++;
      line[n][b] = {8'hD0, 8'(seq), 8'(n), 8'(b)};
    end
    old = rep_seen;
    @(negedge clk);
    chk(req_ready == 1, "R7 ready when idle", 64'(req_ready), 64'd1);
    req_valid = 1; req_write = w; req_node = NW'(n); req_blk = BW'(b);
    @(negedge clk);
    req_valid = 0;
    chk(busy == 1 && req_ready == 0, "R7 busy after accept", {busy, req_ready}, 2'b10);
    while (rep_seen == old) @(negedge clk);
    @(negedge clk);
    done_valid = 1; done_node = NW'((n + 1) % NODES);
    @(negedge clk);
    done_valid = 0;
    chk(busy == 1 && req_ready == 0, "R7 foreign completion ignored", {busy, req_ready}, 2'b10);
    done_valid = 1; done_node = NW'(n);
    @(negedge clk);
    done_valid = 0;
    chk(busy == 0 && req_ready == 1, "R7 released by completion", {busy, req_ready}, 2'b01);
    chk(exp_prb.size() == 0 && exp_mwr.size() == 0, {tag, " all messages seen"},
        64'(exp_prb.size() + exp_mwr.size()), 64'd0);
  endtask

  initial begin
    for (int b = 0; b < BLOCKS; b++) begin
      dp[b] = '0; dd[b] = 0;
      exp_mem[b] = 32'h1000_0000 + b; mem_m[b] = 32'h1000_0000 + b;
      for (int k = 0; k < NODES; k++) line[k][b] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && req_ready == 1, "R1 reset idle", {busy, req_ready}, 2'b01);
    chk({prb_valid, rep_valid, mem_valid} == 3'b000, "R1 reset no messages",
        {prb_valid, rep_valid, mem_valid}, 3'b000);
    do_req(0, 0, 1, "R2 read clean n0");
    do_req(0, 2, 1, "R2 read clean n2");
    do_req(0, 3, 1, "R2 read clean n3");
    do_req(1, 2, 1, "R4 write with sharers, own bit skipped");
    do_req(0, 1, 1, "R3 read dirty recall");
    do_req(1, 3, 1, "R4 write after shared recall");
    do_req(1, 0, 1, "R5 write dirty transfer");
    do_req(0, 2, 1, "R3 R8 single owner recall");
    do_req(1, 0, 5, "R4 write no sharers");
    do_req(0, 1, 5, "R3 read dirty b5");
    do_req(0, 3, 7, "R2 read clean b7");
    do_req(1, 3, 7, "R4 write by sole sharer");
    do_req(1, 1, 7, "R5 write dirty b7");
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule